// File: doc/BRIEF.md
# GF(128) Symbol Derandomizer

This block strips the scrambling from a stream of 7-bit symbols. A three-stage shift register holds one GF(128) symbol per stage. Its oldest stage is the keystream symbol, and it is XORed onto each incoming symbol. The result leaves combinationally, in the same cycle as the input. The feedback term adds the oldest stage to the middle stage multiplied by alpha cubed. The field is built from x^7 + x^3 + 1.

The register moves only when a symbol is accepted. A frame-start pulse reloads all stages to the all-ones symbol. Upstream logic finds the frame sync, removes the sync pattern and delivers only the data symbols between syncs. It marks the first data symbol of each frame with the frame-start pulse. Scrambling and descrambling use the same operation, so the same block also serves as the scrambler at a transmitter.

Top module: `gf_derandomizer`

## Requirements
- R1: `sym_o` equals `sym_i` XOR the current keystream symbol in the same cycle, with no register in the path, and `sym_valid_o` equals `sym_valid_i` in the same cycle.
- R2: The keystream symbol is the oldest of three 7-bit stages. Each accepted symbol moves every stage one place toward the oldest.
- R3: When `frame_start_i` is high, all three stages are loaded with 7'h7F. If a valid symbol arrives in the same cycle, that symbol is descrambled with 7'h7F, and the register advances from the reloaded state.
- R4: The new youngest stage is the oldest stage XOR alpha^3 times the middle stage. The field uses the polynomial x^7 + x^3 + 1, with alpha = 7'b0000010. From the all-ones start, the keystream runs 7F, 7F, 7F, 38, 38, 24.
- R5: In a cycle with `sym_valid_i` and `frame_start_i` both low, the register keeps its value. The next accepted symbol therefore sees the keystream that was pending before that cycle.
- R6: After reset, all stages hold 7'h7F. The first accepted symbol is descrambled with 7'h7F even when no frame-start pulse has been seen.
- R7: A frame scrambled by the same register, started from the same reload, comes back unchanged after passing through the block.
- R8: A frame-start pulse with `sym_valid_i` low reloads the register and does not advance it. The next valid symbol is descrambled with 7'h7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_i | input | 7 | Scrambled symbol |
| sym_valid_i | input | 1 | Marks `sym_i` as a data symbol to process |
| frame_start_i | input | 1 | Reloads the register at a frame boundary |
| sym_o | output | 7 | Descrambled symbol |
| sym_valid_o | output | 1 | Marks `sym_o` as valid |

## Verification
The register properties assume that every cycle is one of three kinds: an accepted symbol, a reload, or an idle cycle. They also assume that a frame-start pulse counts as a reload whether or not a symbol comes with it. The bench drives `frame_start_i` and `sym_valid_i` on the falling edge and holds them stable through the next rising edge. This covers all four combinations of the two strobes, including frame pulses with no symbol and long idle gaps in the middle of a frame. The bench never applies reset in the middle of a cycle in which a strobe is high.

// File: rtl/gf_derand_pkg.sv
package gf_derand_pkg;
  localparam int unsigned SYM_W   = 7;
  localparam int unsigned STAGES  = 3;
  localparam int unsigned TAP_IDX = 1;
  localparam int unsigned TAP_POW = 3;
  // x^7 + x^3 + 1 with the x^7 term removed
  localparam logic [SYM_W-1:0] POLY_LO = 7'h09;
  localparam logic [SYM_W-1:0] SEED    = 7'h7F;

  typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/gf_alpha_pow_mul.sv
module gf_alpha_pow_mul #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] POLY = 7'h09,
  parameter int unsigned POW = 3
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] p_o
);
  logic [W-1:0] chain [POW+1];

  assign chain[0] = a_i;

  // one multiply by alpha per step: shift, then reduce on carry-out
  for (genvar k = 0; k < POW; k++) begin : g_step
    assign chain[k+1] = {chain[k][W-2:0], 1'b0} ^ (chain[k][W-1] ? POLY : '0);
  end

  assign p_o = chain[POW];

  // a nonzero operand times a nonzero constant is never zero
  always_comb begin
    p_nonzero_r4: assert (a_i == '0 || p_o != '0);
  end
endmodule

// File: rtl/gf_keystream_lfsr.sv
module gf_keystream_lfsr
  import gf_derand_pkg::*;
#(
  parameter int unsigned W = SYM_W,
  parameter int unsigned N = STAGES,
  parameter int unsigned TAP = TAP_IDX,
  parameter int unsigned POW = TAP_POW,
  parameter logic [W-1:0] POLY = POLY_LO,
  parameter logic [W-1:0] INIT = SEED
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] key_o
);
  localparam int unsigned OLD = N - 1;

  logic [W-1:0] stage_q [N];
  logic [W-1:0] base    [N];
  logic [W-1:0] nxt     [N];
  logic [W-1:0] tap_mul;
  logic [W-1:0] fb;

  // a reload takes effect before any shift in the same cycle
  for (genvar i = 0; i < N; i++) begin : g_base
    assign base[i] = load_i ? INIT : stage_q[i];
  end

  gf_alpha_pow_mul #(.W(W), .POLY(POLY), .POW(POW)) u_tap_mul (
    .a_i(base[TAP]),
    .p_o(tap_mul)
  );

  assign fb    = base[OLD] ^ tap_mul;
  assign key_o = base[OLD];

  assign nxt[0] = step_i ? fb : base[0];
  for (genvar i = 1; i < N; i++) begin : g_shift
    assign nxt[i] = step_i ? base[i-1] : base[i];
  end

  for (genvar i = 0; i < N; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= INIT;
      else         stage_q[i] <= nxt[i];
    end

    p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && !step_i) |=> stage_q[i] == INIT);

    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !step_i) |=> $stable(stage_q[i]));
  end

  for (genvar i = 1; i < N; i++) begin : g_shift_chk
    p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_i && !load_i) |=> stage_q[i] == $past(stage_q[i-1]));
  end
endmodule

// File: rtl/gf_derandomizer.sv
module gf_derandomizer
  import gf_derand_pkg::*;
#(
  parameter int unsigned W = SYM_W,
  parameter logic [W-1:0] INIT = SEED
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sym_i,
  input  logic         sym_valid_i,
  input  logic         frame_start_i,
  output logic [W-1:0] sym_o,
  output logic         sym_valid_o
);
  logic [W-1:0] key;

  gf_keystream_lfsr #(
    .W(W), .N(STAGES), .TAP(TAP_IDX), .POW(TAP_POW), .POLY(POLY_LO), .INIT(INIT)
  ) u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(frame_start_i),
    .step_i(sym_valid_i),
    .key_o (key)
  );

  assign sym_o       = sym_i ^ key;
  assign sym_valid_o = sym_valid_i;

  p_frame_key_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |-> (sym_o ^ sym_i) == INIT);
endmodule

// File: tb/gf_derandomizer_test.sv
module gf_derandomizer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  localparam int FRAME_LEN = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] sym_in = '0;
  logic       vld_in = 1'b0;
  logic       frm_in = 1'b0;
  logic [6:0] sym_out;
  logic       vld_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gf_derandomizer uut (
    .clk_i(clk), .rst_ni(rst_n), .sym_i(sym_in), .sym_valid_i(vld_in),
    .frame_start_i(frm_in), .sym_o(sym_out), .sym_valid_o(vld_out)
  );

  // {frame, valid, sym_in, expected sym_out}
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 7'h00, 7'h7F},  // R3 frame with symbol
    {1'b0, 1'b1, 7'h00, 7'h7F},  // R4
    {1'b0, 1'b1, 7'h7F, 7'h00},  // R4
    {1'b0, 1'b0, 7'h55, 7'h6D},  // R5 idle, key 38 held
    {1'b0, 1'b1, 7'h00, 7'h38},  // R5 / R4
    {1'b0, 1'b1, 7'h38, 7'h00},  // R4
    {1'b0, 1'b1, 7'h00, 7'h24},  // R4
    {1'b1, 1'b1, 7'h00, 7'h7F},  // R3 mid-frame reload
    {1'b1, 1'b0, 7'h00, 7'h7F},  // R8 reload without symbol
    {1'b0, 1'b1, 7'h01, 7'h7E},  // R8 first after bare reload
    {1'b0, 1'b1, 7'h00, 7'h7F}   // R3 advance from reload
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic v, input logic [6:0] d);
    @(negedge clk);
    frm_in = f; vld_in = v; sym_in = d;
    #1;
  endtask

  // bench model of the register
  logic [6:0] m [3];

  function automatic logic [6:0] times_alpha(input logic [6:0] x);
    return x[6] ? ({x[5:0], 1'b0} ^ 7'h09) : {x[5:0], 1'b0};
  endfunction

  task automatic model_reload();
    m[0] = 7'h7F; m[1] = 7'h7F; m[2] = 7'h7F;
  endtask

  task automatic model_step();
    logic [6:0] t;
    t = times_alpha(times_alpha(times_alpha(m[1])));
    t = t ^ m[2];
    m[2] = m[1]; m[1] = m[0]; m[0] = t;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] plain [FRAME_LEN];
    logic [6:0] scr   [FRAME_LEN];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: reset state, no frame pulse
    drive(1'b0, 1'b1, 7'h2A);
    check("R6", sym_out, 7'h2A ^ 7'h7F);
    check("R1 valid", {6'd0, vld_out}, 7'h01);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][15], VEC[i][14], VEC[i][13:7]);
      check("R1/R3/R4/R5/R8 vector", sym_out, VEC[i][6:0]);
      check("R1 valid", {6'd0, vld_out}, {6'd0, VEC[i][14]});
    end

    // R7: scramble with model, descramble through block, with idle gaps
    model_reload();
    for (int i = 0; i < FRAME_LEN; i++) begin
      plain[i] = 7'((i * 37 + 11) % 128);
      scr[i] = plain[i] ^ m[2];
      model_step();
    end
    for (int i = 0; i < FRAME_LEN; i++) begin
      if (i % 17 == 5) begin
        drive(1'b0, 1'b0, 7'h11);
        check("R1 idle valid", {6'd0, vld_out}, 7'h00);
      end
      drive(i == 0, 1'b1, scr[i]);
      check("R7", sym_out, plain[i]);
    end

    // R2/R4: raw keystream over a long run against model
    drive(1'b1, 1'b0, 7'h00);
    model_reload();
    for (int i = 0; i < 60; i++) begin
      drive(1'b0, 1'b1, 7'h00);
      check("R2/R4 keystream", sym_out, m[2]);
      model_step();
    end

    // R6: reset mid-stream restores seed
    @(negedge clk);
    vld_in = 1'b0; frm_in = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b1, 7'h00);
    check("R6 after reset", sym_out, 7'h7F);
    drive(1'b0, 1'b0, 7'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule